// File: doc/BRIEF.md
# Coincidence Scaler Bank

This block counts trigger activity for a coincidence trigger crate. It has eight term counters, one for each of the four fold levels in each of the two detector views, and one wider counter for the combined logic trigger. Each counter advances once for every low-to-high transition of its input. The inputs are sampled on the system clock and are assumed to be synchronous to it.

Control arrives as decoded bus commands: a valid strobe with a 5-bit function code and a 4-bit sub-address. Three function codes are recognised. One returns a counter word on the read port one cycle later. One clears a single counter or all of them. One arms counting. The combined-trigger counter is wider than the read word, so it is read in two halves. Reading the low half also copies the high part into a holding register. The high-half read then returns that copy, so the two halves always come from the same instant. A crate-wide clear input returns the counting state to its power-on condition.

Top module: `scaler_bank`

## Requirements
- R1: After reset, every counter, the arm flag and the holding register are zero, and `rd_valid` and `rd_data` are low.
- R2: Counting is off after reset. A command with function 17 at sub-address 5 turns it on from the next cycle. Input edges seen before that leave every counter unchanged.
- R3: While counting is on, a counter increases by exactly one for each clock sample where its input is high and the previous sample was low. An input held high for several cycles counts once.
- R4: Each counter wraps to zero at full scale: 2^CNT_W for term counters and 2^LTO_W for the trigger counter.
- R5: A function-2 command returns a word on `rd_data` with `rd_valid` high, one cycle after the command. Sub-addresses 0–7 select term counters 0–7, which are `term_in` bits 0–7 (bits 0–3 are view X folds 1–4, bits 4–7 are view Y folds 1–4). The value is zero-extended to WORD_W.
- R6: Function 2 at sub-address 14 returns the low WORD_W bits of the trigger counter and stores its upper LTO_W−WORD_W bits in the holding register. Sub-address 15 returns the holding register zero-extended, so all bits above LTO_W−WORD_W read 0.
- R7: Function 11 clears counters. Sub-address 0 clears the trigger counter, 1–8 clear term counters 0–7, and 15 clears all nine. Other sub-addresses leave every counter unchanged.
- R8: When a clear and a counted edge for the same counter fall in the same cycle, the counter ends at zero.
- R9: A one-cycle pulse on `crate_clr` zeroes all counters, the holding register and the arm flag.
- R10: A function-2 command at sub-addresses 8–13, or a command with any other unused function code, leaves `rd_valid` low and `rd_data` zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| crate_clr | input | 1 | Synchronous crate-wide clear pulse |
| cmd_valid | input | 1 | Command strobe |
| cmd_func | input | 5 | Function code |
| cmd_sa | input | 4 | Sub-address |
| term_in | input | 8 | Coincidence term inputs, X folds 1–4 then Y folds 1–4 |
| lto_in | input | 1 | Combined logic trigger input |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | WORD_W | Read word |

## Verification
The bench uses a small configuration: 6-bit words, 6-bit terms and a 9-bit trigger counter. This lets it sweep the trigger counter through a full wrap, reading both halves after every edge, and step one term counter across its full scale.

- A wrong high/low split, or a holding register refreshed on the wrong read, shows up as a torn or stale high half. The bench also advances the counter between the two reads and checks that the held value has not moved.
- If the clear or the count wins the wrong way in a tie, or the individual clear map is offset by one, the wrong counter survives a clear. So does a non-zero value after a simultaneous clear and edge.
- A level-sensitive counter would run away on a held input.
- A crate clear that missed the arm flag would let counting continue.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int N_TERMS = 8;

    localparam logic [4:0] FN_READ  = 5'd2;
    localparam logic [4:0] FN_CLEAR = 5'd11;
    localparam logic [4:0] FN_ARM   = 5'd17;

    localparam logic [3:0] SA_ARM     = 4'd5;
    localparam logic [3:0] SA_CLR_LTO = 4'd0;
    localparam logic [3:0] SA_CLR_ALL = 4'd15;
    localparam logic [3:0] SA_LTO_LO  = 4'd14;
    localparam logic [3:0] SA_LTO_HI  = 4'd15;

    typedef struct packed {
        logic rd;
        logic clr;
        logic arm;
    } cmd_dec_t;

endpackage

// File: rtl/sb_edge_det.sv
module sb_edge_det #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_in,
    output logic [N-1:0] rise
);

    typedef struct packed {
        logic [N-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_in;
        rise      = sig_in & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a rising edge cannot be reported in two consecutive cycles
    AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((rise & $past(rise)) == '0)); // R3

endmodule

// File: rtl/sb_counter.sv
module sb_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)      st_d.cnt = '0;
        else if (inc) st_d.cnt = st_q.cnt + W'(1);
        cnt = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R8
    AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (cnt == W'($past(cnt) + W'(1)))); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt)); // R3

endmodule

// File: rtl/sb_readout.sv
module sb_readout #(
    parameter int N_T    = 8,
    parameter int CNT_W  = 16,
    parameter int LTO_W  = 24,
    parameter int WORD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_hold,
    input  logic               rd_req,
    input  logic [3:0]         rd_sa,
    input  logic [N_T*CNT_W-1:0] term_cnt,
    input  logic [LTO_W-1:0]   lto_cnt,
    output logic               rd_valid,
    output logic [WORD_W-1:0]  rd_data
);

    localparam int HI_W = LTO_W - WORD_W;
    localparam logic [3:0] SA_LO = 4'd14;
    localparam logic [3:0] SA_HI = 4'd15;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
        logic [HI_W-1:0]   hold;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic              hit;
    logic [WORD_W-1:0] word;

    always_comb begin
        hit  = 1'b0;
        word = '0;
        for (int i = 0; i < N_T; i++) begin
            if (rd_sa == 4'(i)) begin
                hit  = 1'b1;
                word = WORD_W'(term_cnt[i*CNT_W +: CNT_W]);
            end
        end
        if (rd_sa == SA_LO) begin
            hit  = 1'b1;
            word = lto_cnt[WORD_W-1:0];
        end
        if (rd_sa == SA_HI) begin
            hit  = 1'b1;
            word = WORD_W'(st_q.hold);
        end

        st_d       = st_q;
        st_d.valid = rd_req && hit;
        st_d.data  = (rd_req && hit) ? word : '0;
        if (rd_req && rd_sa == SA_LO) st_d.hold = lto_cnt[LTO_W-1:WORD_W];
        if (clr_hold)                 st_d.hold = '0;

        rd_valid = st_q.valid;
        rd_data  = st_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_sa == SA_HI) |=> ((rd_data >> HI_W) == '0)); // R6
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_sa >= 4'd8 && rd_sa <= 4'd13) |=> !rd_valid); // R10
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_sa < 4'd8) |=> rd_valid); // R5

endmodule

// File: rtl/scaler_bank.sv
module scaler_bank
    import sb_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int LTO_W  = 24,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crate_clr,
    input  logic              cmd_valid,
    input  logic [4:0]        cmd_func,
    input  logic [3:0]        cmd_sa,
    input  logic [7:0]        term_in,
    input  logic              lto_in,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);

    localparam int FLAT_W = N_TERMS * CNT_W;

    typedef struct packed {
        logic en;
    } ctrl_st_t;

    cmd_dec_t            dec;
    ctrl_st_t            ctrl_d, ctrl_q;
    logic [N_TERMS:0]    rise;
    logic [N_TERMS-1:0]  term_clr;
    logic [N_TERMS-1:0]  term_inc;
    logic [FLAT_W-1:0]   term_cnt;
    logic                lto_clr;
    logic                lto_inc;
    logic [LTO_W-1:0]    lto_cnt;

    always_comb begin
        dec.rd  = cmd_valid && (cmd_func == FN_READ);
        dec.clr = cmd_valid && (cmd_func == FN_CLEAR);
        dec.arm = cmd_valid && (cmd_func == FN_ARM) && (cmd_sa == SA_ARM);

        ctrl_d = ctrl_q;
        if (dec.arm)   ctrl_d.en = 1'b1;
        if (crate_clr) ctrl_d.en = 1'b0;

        lto_clr = crate_clr ||
                  (dec.clr && (cmd_sa == SA_CLR_LTO || cmd_sa == SA_CLR_ALL));
        lto_inc = ctrl_q.en && rise[N_TERMS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    sb_edge_det #(.N(N_TERMS + 1)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in ({lto_in, term_in}),
        .rise   (rise)
    );

    for (genvar g = 0; g < N_TERMS; g++) begin : g_term
        assign term_clr[g] = crate_clr ||
            (dec.clr && (cmd_sa == 4'(g + 1) || cmd_sa == SA_CLR_ALL));
        assign term_inc[g] = ctrl_q.en && rise[g];

        sb_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (term_clr[g]),
            .inc   (term_inc[g]),
            .cnt   (term_cnt[g*CNT_W +: CNT_W])
        );
    end

    sb_counter #(.W(LTO_W)) u_lto (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (lto_clr),
        .inc   (lto_inc),
        .cnt   (lto_cnt)
    );

    sb_readout #(
        .N_T    (N_TERMS),
        .CNT_W  (CNT_W),
        .LTO_W  (LTO_W),
        .WORD_W (WORD_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_hold (crate_clr),
        .rd_req   (dec.rd),
        .rd_sa    (cmd_sa),
        .term_cnt (term_cnt),
        .lto_cnt  (lto_cnt),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    AST_DISARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.en && !lto_clr) |=> $stable(lto_cnt)); // R2
    AST_CRATE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        crate_clr |=> (!ctrl_q.en && lto_cnt == '0 && term_cnt == '0)); // R9
    AST_RESET_STATE: assert property (@(posedge clk)
        $rose(rst_n) |-> (lto_cnt == '0 && !rd_valid)); // R1

endmodule

// File: tb/scaler_bank_test.sv
module scaler_bank_test;

    localparam int CW = 6;
    localparam int LW = 9;
    localparam int WW = 6;
    localparam int TMOD = 1 << CW;
    localparam int LMOD = 1 << LW;
    localparam int WMOD = 1 << WW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          crate_clr = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [4:0]    cmd_func = '0;
    logic [3:0]    cmd_sa = '0;
    logic [7:0]    term_in = '0;
    logic          lto_in = 1'b0;
    logic          rd_valid;
    logic [WW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    int exp_term [8];
    int exp_lto = 0;
    bit armed = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    scaler_bank #(.CNT_W(CW), .LTO_W(LW), .WORD_W(WW)) uut (
        .clk(clk), .rst_n(rst_n), .crate_clr(crate_clr), .cmd_valid(cmd_valid),
        .cmd_func(cmd_func), .cmd_sa(cmd_sa), .term_in(term_in), .lto_in(lto_in),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [4:0] f, input logic [3:0] a);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_func = f; cmd_sa = a;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rd(input logic [4:0] f, input logic [3:0] a,
                      output int v, output int d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_func = f; cmd_sa = a;
        @(negedge clk);
        v = int'(rd_valid); d = int'(rd_data);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] m, input logic l);
        @(negedge clk);
        term_in = m; lto_in = l;
        @(negedge clk);
        term_in = '0; lto_in = 1'b0;
        if (armed) begin
            for (int i = 0; i < 8; i++)
                if (m[i]) exp_term[i] = (exp_term[i] + 1) % TMOD;
            if (l) exp_lto = (exp_lto + 1) % LMOD;
        end
    endtask

    task automatic read_all(input string req);
        int v, d;
        for (int i = 0; i < 8; i++) begin
            rd(5'd2, 4'(i), v, d);
            chk({req, " valid"}, v, 1);
            chk({req, " term"}, d, exp_term[i]);
        end
        rd(5'd2, 4'd14, v, d);
        chk({req, " lto low"}, d, exp_lto % WMOD);
        rd(5'd2, 4'd15, v, d);
        chk({req, " lto high"}, d, exp_lto / WMOD);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        if (!done) $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v, d;
        for (int i = 0; i < 8; i++) exp_term[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_valid idle", int'(rd_valid), 0);
        chk("R1 rd_data idle", int'(rd_data), 0);
        read_all("R1");

        // R2: edges before arming are ignored
        for (int k = 0; k < 3; k++) pulse(8'hFF, 1'b1);
        read_all("R2 disarmed");
        issue(5'd17, 4'd5);
        armed = 1'b1;

        // R3/R5: distinct count per channel
        for (int i = 0; i < 8; i++)
            for (int k = 0; k <= i; k++) pulse(8'(1 << i), 1'b0);
        for (int k = 0; k < 5; k++) pulse(8'h00, 1'b1);
        read_all("R5 mapping");

        // R3: held-high input counts once
        @(negedge clk); term_in = 8'h01;
        repeat (6) @(negedge clk);
        term_in = 8'h00;
        exp_term[0] = (exp_term[0] + 1) % TMOD;
        read_all("R3 held level");

        // R4: term 2 swept over full scale, read each step
        for (int k = 0; k < TMOD + 2; k++) begin
            pulse(8'h04, 1'b0);
            rd(5'd2, 4'd2, v, d);
            chk("R4 term wrap", d, exp_term[2]);
        end

        // R4/R6: trigger counter swept past wrap, both halves each step
        for (int k = 0; k < LMOD + 8; k++) begin
            pulse(8'h00, 1'b1);
            rd(5'd2, 4'd14, v, d);
            chk("R6 low half", d, exp_lto % WMOD);
            rd(5'd2, 4'd15, v, d);
            chk("R4 high half", d, exp_lto / WMOD);
        end

        // R6: held high part does not follow the counter
        begin
            int held;
            rd(5'd2, 4'd14, v, d);
            held = exp_lto / WMOD;
            for (int k = 0; k < WMOD; k++) pulse(8'h00, 1'b1);
            rd(5'd2, 4'd15, v, d);
            chk("R6 stale hold", d, held);
            rd(5'd2, 4'd14, v, d);
            rd(5'd2, 4'd15, v, d);
            chk("R6 refreshed hold", d, exp_lto / WMOD);
        end

        // R7: unused clear addresses leave everything
        for (int a = 9; a <= 14; a++) issue(5'd11, 4'(a));
        read_all("R7 unused clear");

        // R7: individual clears
        for (int a = 1; a <= 8; a++) begin
            pulse(8'hFF, 1'b1);
            issue(5'd11, 4'(a));
            exp_term[a-1] = 0;
            read_all("R7 single clear");
        end
        issue(5'd11, 4'd0);
        exp_lto = 0;
        read_all("R7 lto clear");
        pulse(8'hFF, 1'b1);
        issue(5'd11, 4'd15);
        for (int i = 0; i < 8; i++) exp_term[i] = 0;
        exp_lto = 0;
        read_all("R7 clear all");

        // R8: clear and edge in the same cycle
        pulse(8'h08, 1'b1);
        @(negedge clk);
        term_in = 8'h08; cmd_valid = 1'b1; cmd_func = 5'd11; cmd_sa = 4'd4;
        @(negedge clk);
        cmd_valid = 1'b0; term_in = 8'h00;
        exp_term[3] = 0;
        read_all("R8 clear vs edge term");
        @(negedge clk);
        lto_in = 1'b1; term_in = 8'h10; cmd_valid = 1'b1; cmd_func = 5'd11; cmd_sa = 4'd15;
        @(negedge clk);
        cmd_valid = 1'b0; lto_in = 1'b0; term_in = 8'h00;
        for (int i = 0; i < 8; i++) exp_term[i] = 0;
        exp_lto = 0;
        read_all("R8 clear all vs edge");

        // R9: crate clear
        for (int k = 0; k < 70; k++) pulse(8'hA5, 1'b1);
        rd(5'd2, 4'd14, v, d);
        @(negedge clk); crate_clr = 1'b1;
        @(negedge clk); crate_clr = 1'b0;
        armed = 1'b0;
        for (int i = 0; i < 8; i++) exp_term[i] = 0;
        exp_lto = 0;
        rd(5'd2, 4'd15, v, d);
        chk("R9 hold cleared", d, 0);
        pulse(8'hFF, 1'b1);
        read_all("R9 disarmed and zero");

        // R10: unmapped reads and unused functions
        for (int a = 8; a <= 13; a++) begin
            rd(5'd2, 4'(a), v, d);
            chk("R10 unmapped valid", v, 0);
            chk("R10 unmapped data", d, 0);
        end
        rd(5'd1, 4'd0, v, d);
        chk("R10 other function valid", v, 0);
        rd(5'd3, 4'd14, v, d);
        chk("R10 other function data", d, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule